// File: doc/BRIEF.md
# Interrupt Aggregating Control Register File

This block is a small system control register bank on an 8-bit, byte-addressed host bus. It gathers eight level-driven sub-interrupt lines into an interrupt status register. It qualifies that status with a mask register and drives one registered interrupt request toward the host. Alongside these it keeps a routing byte, a read-only revision field, and a set of configuration registers of one, two and four bytes. These configuration registers are pure storage and have no side effects.

The host does each access one byte at a time. A wider transfer is broken into successive byte accesses at rising offsets by logic outside this block, with the least significant byte at the lowest offset. A write strobe stores one byte into the register lane it addresses. A read strobe loads the addressed byte into a read-data register, and that register holds its value until the next read. An access to an offset with no register behind it reads as zero and changes nothing. When the error option is enabled, such an access also raises a one-cycle error pulse.

Each sub-interrupt line changes its status bit only when the line changes level. A rising line sets the bit and a falling line clears it. Between changes, the host may overwrite the status byte freely.

Top module: `sysctl_regbank`

## Requirements
- R1: After reset, irq_out is 0 and every register reads 0x00, except the revision field.
- R2: A 0-to-1 change on sub_irq[k] sets status bit k (offset 0x50) at the next clock edge, and a 1-to-0 change clears it. Lines 0 to 4 serve the storage, card, USB host, serial and display functions; lines 5 to 7 are spare but behave the same way.
- R3: A host write to offset 0x50 replaces the status byte. A line held steady does not set its bit again afterwards. If a line changes in the same cycle as a status write, the line change wins for that bit.
- R4: irq_out is a register. It equals 1 exactly when status AND mask, as held in the previous cycle, is nonzero. So it follows a status or mask change one clock later.
- R5: The mask byte at 0x52 and the routing byte at 0x54 are read/write. The routing byte has no effect on irq_out.
- R6: Offset 0x08 reads 0x03 and offset 0x09 reads 0x00. Writes to either offset are ignored and raise no error.
- R7: The multi-byte registers are little-endian: 16-bit registers at 0x98, 0x9A and 0xE4, and a 32-bit register at 0x9C–0x9F. A byte write changes only the lane it addresses.
- R8: The single-byte registers at 0xE0, 0xFC and 0xFF are read/write.
- R9: A read of an unmapped offset returns 0x00, and a write to one changes no register. With ERR_EN=1, bus_err is 1 in the cycle after such an access and 0 after any mapped access.
- R10: bus_rdata is loaded at the clock edge that samples bus_rd_en and holds until the next read. A read and a write to the same offset in the same cycle return the value before the write.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 8 | Byte offset of the access |
| bus_wr_en | input | 1 | Write strobe, one byte per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rd_en | input | 1 | Read strobe |
| bus_rdata | output | 8 | Registered read data |
| bus_err | output | 1 | One-cycle pulse after an access to an unmapped offset |
| sub_irq | input | 8 | Level-sensitive sub-interrupt lines |
| irq_out | output | 1 | Registered combined interrupt request |

## Verification
The hardest case to reach is a collision: a sub-interrupt line changes level in the very cycle that the host writes the status byte. This needs the line edge and the write strobe in the same cycle. The bench drives both at the same falling clock edge and then reads status back to confirm that the line's bit won. A similar case is a line held high after software has cleared its bit. The bench holds the line steady across several idle cycles and reads status again to show the bit does not come back. The one-cycle latency of irq_out is checked by sampling it on both sides of the edge that loads the mask.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int DW = 8;
  localparam int AW = 8;
  localparam int NUM_CFG = 9;
  localparam int IDX_MASK = 0;

  localparam logic [AW-1:0] STATUS_OFS = 8'h50;
  localparam logic [AW-1:0] REV_OFS    = 8'h08;
  localparam logic [DW-1:0] REV_LO_VAL = 8'h03;
  localparam logic [DW-1:0] REV_HI_VAL = 8'h00;

  // storage registers: base offset and byte count
  function automatic logic [AW-1:0] cfg_base(input int i);
    case (i)
      0: return 8'h52; // mask
      1: return 8'h54; // routing
      2: return 8'h98; // clock control
      3: return 8'h9A; // second pll
      4: return 8'h9C; // first pll, 32-bit
      5: return 8'hE0; // function enable
      6: return 8'hE4; // mode control
      7: return 8'hFC; // configuration
      default: return 8'hFF; // debug
    endcase
  endfunction

  function automatic int cfg_bytes(input int i);
    case (i)
      2, 3, 6: return 2;
      4:       return 4;
      default: return 1;
    endcase
  endfunction
endpackage

// File: rtl/sysctl_lane_reg.sv
module sysctl_lane_reg #(
  parameter int NBYTES = 1,
  parameter logic [7:0] BASE = 8'h00,
  localparam int IDXW = (NBYTES > 1) ? $clog2(NBYTES) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [7:0]        addr,
  input  logic [7:0]        wdata,
  output logic              hit,
  output logic [IDXW-1:0]   lane,
  output logic [8*NBYTES-1:0] q
);
  always_comb begin
    int off;
    off  = int'(addr) - int'(BASE);
    hit  = (off >= 0) && (off < NBYTES);
    lane = IDXW'(off);
  end

  for (genvar b = 0; b < NBYTES; b++) begin : g_lane
    logic [7:0] lane_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        lane_q <= '0;
      else if (wr_en && hit && lane == IDXW'(b))
        lane_q <= wdata;
    end
    assign q[b*8 +: 8] = lane_q;
  end
endmodule

// File: rtl/sysctl_irq_agg.sv
module sysctl_irq_agg #(
  parameter int N = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] src,
  input  logic         sw_we,
  input  logic [N-1:0] sw_data,
  input  logic [N-1:0] mask,
  output logic [N-1:0] status,
  output logic         irq_q
);
  logic [N-1:0] src_prev, rise, fall, status_d;

  assign rise = src & ~src_prev;
  assign fall = ~src & src_prev;

  always_comb begin
    status_d = sw_we ? sw_data : status;
    status_d = (status_d | rise) & ~fall;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      src_prev <= '0;
      status   <= '0;
      irq_q    <= 1'b0;
    end else begin
      src_prev <= src;
      status   <= status_d;
      irq_q    <= |(status & mask);
    end
  end
endmodule

// File: rtl/sysctl_regbank.sv
module sysctl_regbank
  import sysctl_pkg::*;
#(
  parameter bit ERR_EN = 1'b1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] bus_addr,
  input  logic          bus_wr_en,
  input  logic [DW-1:0] bus_wdata,
  input  logic          bus_rd_en,
  output logic [DW-1:0] bus_rdata,
  output logic          bus_err,
  input  logic [DW-1:0] sub_irq,
  output logic          irq_out
);
  logic [NUM_CFG-1:0] cfg_hit;
  logic [DW-1:0]      cfg_rbyte [NUM_CFG];
  logic [DW-1:0]      mask_q;
  logic [DW-1:0]      status_q;
  logic               status_hit, rev_hit, mapped;
  logic [DW-1:0]      rd_mux;
  logic [DW-1:0]      rdata_q;

  for (genvar g = 0; g < NUM_CFG; g++) begin : g_cfg
    localparam int NB = cfg_bytes(g);
    localparam int LW = (NB > 1) ? $clog2(NB) : 1;
    logic [LW-1:0]   lane_w;
    logic [8*NB-1:0] q_w;

    sysctl_lane_reg #(.NBYTES(NB), .BASE(cfg_base(g))) u_reg (
      .clk  (clk),
      .rst_n(rst_n),
      .wr_en(bus_wr_en),
      .addr (bus_addr),
      .wdata(bus_wdata),
      .hit  (cfg_hit[g]),
      .lane (lane_w),
      .q    (q_w)
    );

    if (NB == 1) begin : g_one
      assign cfg_rbyte[g] = cfg_hit[g] ? q_w[7:0] : '0;
      logic unused_lane;
      assign unused_lane = ^lane_w;
    end else begin : g_multi
      assign cfg_rbyte[g] = cfg_hit[g] ? q_w[lane_w*8 +: 8] : '0;
    end

    if (g == IDX_MASK) begin : g_mask
      assign mask_q = q_w[7:0];
    end
  end

  assign status_hit = (bus_addr == STATUS_OFS);
  assign rev_hit    = (bus_addr[AW-1:1] == REV_OFS[AW-1:1]);

  sysctl_irq_agg #(.N(DW)) u_irq (
    .clk    (clk),
    .rst_n  (rst_n),
    .src    (sub_irq),
    .sw_we  (bus_wr_en && status_hit),
    .sw_data(bus_wdata),
    .mask   (mask_q),
    .status (status_q),
    .irq_q  (irq_out)
  );

  always_comb begin
    rd_mux = '0;
    for (int i = 0; i < NUM_CFG; i++) rd_mux |= cfg_rbyte[i];
    if (status_hit) rd_mux = status_q;
    if (rev_hit)    rd_mux = bus_addr[0] ? REV_HI_VAL : REV_LO_VAL;
  end

  assign mapped = (|cfg_hit) || status_hit || rev_hit;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         rdata_q <= '0;
    else if (bus_rd_en) rdata_q <= rd_mux;
  end
  assign bus_rdata = rdata_q;

  if (ERR_EN) begin : g_err
    logic err_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) err_q <= 1'b0;
      else        err_q <= (bus_rd_en || bus_wr_en) && !mapped;
    end
    assign bus_err = err_q;
  end else begin : g_noerr
    assign bus_err = 1'b0;
  end
endmodule

// File: rtl/sysctl_regbank_chk.sv
module sysctl_regbank_chk #(
  parameter bit ERR_EN = 1'b1
) (
  input logic       clk,
  input logic       rst_n,
  input logic [7:0] bus_addr,
  input logic       bus_wr_en,
  input logic       bus_rd_en,
  input logic [7:0] bus_rdata,
  input logic       bus_err,
  input logic [7:0] sub_irq,
  input logic       irq_out,
  input logic [7:0] status_q,
  input logic [7:0] mask_q
);
  logic [7:0] sub_d, rise, fall;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sub_d <= '0;
    else        sub_d <= sub_irq;
  end
  assign rise = sub_irq & ~sub_d;
  assign fall = sub_d & ~sub_irq;

  // R2: a rising line sets its bit
  a_r2_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (rise != 0) |=> ((status_q & $past(rise)) == $past(rise)));

  // R2: a falling line clears its bit
  a_r2_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (fall != 0) |=> ((status_q & $past(fall)) == 8'h00));

  // R4: registered combination of status and mask
  a_r4_irq_registered: assert property (@(posedge clk) disable iff (!rst_n)
    $past(rst_n) |-> (irq_out == ($past(status_q & mask_q) != 8'h00)));

  // R6: revision low byte constant
  a_r6_rev_value: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == 8'h08) |=> (bus_rdata == 8'h03));

  // R9: unmapped read gives zero
  a_r9_unmapped_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd_en && bus_addr == 8'h00) |=> (bus_rdata == 8'h00));

  // R9: error strobe after unmapped access
  a_r9_err_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    (ERR_EN && (bus_rd_en || bus_wr_en) && bus_addr == 8'h00) |=> bus_err);

  // R10: read data holds without a read
  a_r10_rdata_hold: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(rst_n) && !$past(bus_rd_en)) |-> $stable(bus_rdata));
endmodule

bind sysctl_regbank sysctl_regbank_chk #(.ERR_EN(ERR_EN)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .bus_addr (bus_addr),
  .bus_wr_en(bus_wr_en),
  .bus_rd_en(bus_rd_en),
  .bus_rdata(bus_rdata),
  .bus_err  (bus_err),
  .sub_irq  (sub_irq),
  .irq_out  (irq_out),
  .status_q (status_q),
  .mask_q   (mask_q)
);

// File: tb/sim_sysctl_regbank.sv
`timescale 1ns/1ps
module sim_sysctl_regbank;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr_en = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic       bus_rd_en = 1'b0;
  logic [7:0] bus_rdata;
  logic       bus_err;
  logic [7:0] sub_irq = '0;
  logic       irq_out;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  sysctl_regbank u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr_en(bus_wr_en),
    .bus_wdata(bus_wdata), .bus_rd_en(bus_rd_en), .bus_rdata(bus_rdata),
    .bus_err(bus_err), .sub_irq(sub_irq), .irq_out(irq_out)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  // write one byte; returns the error strobe seen afterwards
  task automatic wr(input logic [7:0] a, input logic [7:0] d, output logic err);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    err = bus_err;
  endtask

  task automatic rd(input logic [7:0] a, output logic [7:0] d, output logic err);
    @(negedge clk);
    bus_addr = a; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_rd_en = 1'b0;
    d = bus_rdata; err = bus_err;
  endtask

  task automatic t_reset();
    logic [7:0] d; logic e;
    check("R1 irq_out after reset", irq_out, 0);
    rd(8'h50, d, e); check("R1 status reset", d, 8'h00);
    rd(8'h52, d, e); check("R1 mask reset", d, 8'h00);
    rd(8'h9F, d, e); check("R1 pll top byte reset", d, 8'h00);
    rd(8'hFF, d, e); check("R1 debug reset", d, 8'h00);
  endtask

  task automatic t_revision();
    logic [7:0] d; logic e;
    rd(8'h08, d, e); check("R6 revision low", d, 8'h03);
    rd(8'h09, d, e); check("R6 revision high", d, 8'h00);
    wr(8'h08, 8'hAA, e); check("R6 no error on revision write", e, 0);
    wr(8'h09, 8'h55, e);
    rd(8'h08, d, e); check("R6 revision low after write", d, 8'h03);
    rd(8'h09, d, e); check("R6 revision high after write", d, 8'h00);
  endtask

  task automatic t_status_level();
    logic [7:0] d; logic e;
    @(negedge clk); sub_irq[3] = 1'b1;
    rd(8'h50, d, e); check("R2 rise sets bit 3", d, 8'h08);
    @(negedge clk); sub_irq[3] = 1'b0;
    rd(8'h50, d, e); check("R2 fall clears bit 3", d, 8'h00);
    @(negedge clk); sub_irq[7] = 1'b1;
    rd(8'h50, d, e); check("R2 spare line 7 sets", d, 8'h80);
    @(negedge clk); sub_irq[7] = 1'b0;
    rd(8'h50, d, e); check("R2 spare line 7 clears", d, 8'h00);
  endtask

  task automatic t_status_write();
    logic [7:0] d; logic e;
    @(negedge clk); sub_irq[1] = 1'b1;
    rd(8'h50, d, e); check("R2 line 1 sets", d, 8'h02);
    wr(8'h50, 8'h00, e);
    repeat (4) @(negedge clk);
    rd(8'h50, d, e); check("R3 held line stays cleared", d, 8'h00);
    wr(8'h50, 8'h41, e);
    rd(8'h50, d, e); check("R3 software sets status", d, 8'h41);
    wr(8'h50, 8'h00, e);
    // collision: line 5 rises in the write cycle
    @(negedge clk);
    bus_addr = 8'h50; bus_wdata = 8'h00; bus_wr_en = 1'b1; sub_irq[5] = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0;
    rd(8'h50, d, e); check("R3 line edge wins over write", d, 8'h20);
    // collision: line 1 falls while software writes it to 1
    @(negedge clk);
    bus_addr = 8'h50; bus_wdata = 8'h22; bus_wr_en = 1'b1; sub_irq[1] = 1'b0;
    @(negedge clk);
    bus_wr_en = 1'b0;
    rd(8'h50, d, e); check("R3 falling edge wins over write", d, 8'h20);
    @(negedge clk); sub_irq[5] = 1'b0;
    rd(8'h50, d, e); check("R2 status empty again", d, 8'h00);
  endtask

  task automatic t_irq();
    logic [7:0] d; logic e;
    @(negedge clk); sub_irq[3] = 1'b1;
    repeat (2) @(negedge clk);
    check("R4 masked out keeps irq low", irq_out, 0);
    wr(8'h54, 8'hFF, e);
    @(negedge clk);
    check("R5 routing has no effect on irq", irq_out, 0);
    rd(8'h54, d, e); check("R5 routing readback", d, 8'hFF);
    wr(8'h52, 8'h08, e);
    check("R4 irq not yet high in mask-load cycle", irq_out, 0);
    @(negedge clk);
    check("R4 irq high one clock after mask", irq_out, 1);
    rd(8'h52, d, e); check("R5 mask readback", d, 8'h08);
    @(negedge clk); sub_irq[3] = 1'b0;
    @(negedge clk);
    check("R4 irq still high one edge after fall", irq_out, 1);
    @(negedge clk);
    check("R4 irq low two edges after fall", irq_out, 0);
    wr(8'h52, 8'h00, e);
  endtask

  task automatic t_lanes();
    logic [7:0] d; logic e;
    wr(8'h98, 8'h11, e); wr(8'h99, 8'h22, e);
    wr(8'h98, 8'h33, e);
    rd(8'h98, d, e); check("R7 clock low lane rewritten", d, 8'h33);
    rd(8'h99, d, e); check("R7 clock high lane kept", d, 8'h22);
    wr(8'h9A, 8'h5A, e);
    rd(8'h9B, d, e); check("R7 pll2 high lane untouched", d, 8'h00);
    for (int i = 0; i < 4; i++) wr(8'h9C + 8'(i), 8'hA0 + 8'(i), e);
    wr(8'h9E, 8'hEE, e);
    rd(8'h9C, d, e); check("R7 pll1 byte0", d, 8'hA0);
    rd(8'h9D, d, e); check("R7 pll1 byte1", d, 8'hA1);
    rd(8'h9E, d, e); check("R7 pll1 byte2 rewritten", d, 8'hEE);
    rd(8'h9F, d, e); check("R7 pll1 byte3", d, 8'hA3);
    wr(8'hE5, 8'hC3, e);
    rd(8'hE4, d, e); check("R7 mode low lane", d, 8'h00);
    rd(8'hE5, d, e); check("R7 mode high lane", d, 8'hC3);
  endtask

  task automatic t_bytes();
    logic [7:0] d; logic e;
    wr(8'hE0, 8'h81, e); wr(8'hFC, 8'h7E, e); wr(8'hFF, 8'h99, e);
    rd(8'hE0, d, e); check("R8 function enable", d, 8'h81);
    rd(8'hFC, d, e); check("R8 configuration", d, 8'h7E);
    rd(8'hFF, d, e); check("R8 debug at top offset", d, 8'h99);
  endtask

  task automatic t_unmapped();
    logic [7:0] d; logic e;
    wr(8'h52, 8'h0F, e); check("R9 mapped write no error", e, 0);
    wr(8'h53, 8'h5A, e); check("R9 error after unmapped write", e, 1);
    rd(8'h53, d, e);
    check("R9 unmapped read zero", d, 8'h00);
    check("R9 error after unmapped read", e, 1);
    rd(8'h52, d, e);
    check("R9 neighbour unchanged", d, 8'h0F);
    check("R9 no error after mapped read", e, 0);
    wr(8'hFD, 8'h12, e);
    rd(8'hFC, d, e); check("R9 config unchanged by 0xFD write", d, 8'h7E);
    rd(8'h0A, d, e); check("R9 offset past revision reads zero", d, 8'h00);
    wr(8'h52, 8'h00, e);
  endtask

  task automatic t_rdata();
    logic [7:0] d; logic e;
    rd(8'hE0, d, e);
    repeat (3) @(negedge clk);
    check("R10 rdata holds while idle", bus_rdata, 8'h81);
    wr(8'hFC, 8'h00, e);
    check("R10 rdata holds across write", bus_rdata, 8'h81);
    wr(8'hFC, 8'h7E, e);
    @(negedge clk);
    bus_addr = 8'hFC; bus_wdata = 8'h3C; bus_wr_en = 1'b1; bus_rd_en = 1'b1;
    @(negedge clk);
    bus_wr_en = 1'b0; bus_rd_en = 1'b0;
    check("R10 same-cycle read returns old value", bus_rdata, 8'h7E);
    rd(8'hFC, d, e); check("R10 write landed", d, 8'h3C);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_revision();
    t_status_level();
    t_status_write();
    t_irq();
    t_lanes();
    t_bytes();
    t_unmapped();
    t_rdata();
    repeat (2) @(negedge clk);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule